// File: doc/BRIEF.md
# Move-Only Processor Core

This block is a small in-order core that has no arithmetic unit and no conditional branch. Its whole instruction set is three ways of moving a word: set a register to a constant, read a data word into a register, and write a register to a data word. A fourth encoding sends fetch back to program address zero, so a straight-line program of moves can repeat without end. Data memory is treated as a row of two-word cells that begin on even addresses. An indexed access names a base register that holds a cell address and an offset register that holds 0 or 1. The core joins the two with a bitwise OR, so it needs no adder.

The core fetches one instruction per cycle from an instruction ROM port with combinational read. It drives a word-addressed data port whose memory answers reads one cycle after the request. Computation builds on store-then-load patterns: two stores to two addresses followed by a load tells whether the addresses were equal. The only way to stop is a deliberate access to data address zero. That access raises a sticky halted output, blocks the access and freezes the program counter. An odd base or an offset above one raises a sticky error flag. The result of such an access is left undefined.

Top module: `mvc_core`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, imem_addr is 0, dmem_re and dmem_we are low, and halted and err_flag are low. All registers reset to 0.
- R2: The instruction word is {op[26:25], r[24:22], b[21:19], o[18:16], imm[15:0]}, where op 00 is load-immediate, 01 is load-indexed, 10 is store-indexed and 11 is jump-to-start. Load-immediate sets register r to imm, zero-extended.
- R3: An indexed access uses the address (value of register b) OR (bit 0 of register o), so offset 0 selects the even word of a cell and offset 1 selects the odd word.
- R4: A store-indexed raises dmem_we for exactly that cycle, with dmem_wdata equal to register r and dmem_addr per R3.
- R5: A load-indexed raises dmem_re for that cycle. The word returned on dmem_rdata one cycle later is written to register r. An instruction in the very next cycle that reads r already sees the loaded word.
- R6: If the instruction right after a load-indexed is a load-immediate to the same register, the constant is what remains in that register.
- R7: After a jump-to-start, the next fetch address is 0.
- R8: A load-indexed or store-indexed whose address is 0 raises no strobe, sets halted, and halted stays set until reset.
- R9: While halted, imem_addr does not change and no data strobe is raised, so later instructions have no effect on memory.
- R10: An indexed access with an odd base value or an offset value above 1 sets err_flag, which stays set until reset. Programs that avoid both leave it low.
- R11: Until it halts, the core advances imem_addr by one for every non-jump instruction, one instruction per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Program counter, instruction ROM address |
| imem_data | input | 27 | Instruction word at imem_addr |
| dmem_addr | output | 16 | Data word address |
| dmem_re | output | 1 | Data read request; data returns next cycle |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | 16 | Data write value |
| dmem_rdata | input | 16 | Data read value, valid one cycle after dmem_re |
| halted | output | 1 | Sticky stop after a zero-address access |
| err_flag | output | 1 | Sticky flag for an odd base or an oversized offset |

## Verification
The assertions check on every cycle the properties that must hold at any time. Halted stays set once raised, a halted core keeps its program counter and strobes quiet, no strobe ever carries address zero, a jump is always followed by fetch from zero, and the error flag never clears by itself. Other behaviour only shows up when the bench runs a program and then reads memory. This covers the OR address formation across both words of several cells, stored values, a load feeding the instruction right after it, and the case where a constant overrides a load in flight. It also covers that a faulting store or load left memory untouched and the freeze point stayed on the faulting instruction.

// File: rtl/mvc_pkg.sv
`timescale 1ns/1ps
package mvc_pkg;
   localparam int OP_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_LDI = 2'b00,
      OP_LDX = 2'b01,
      OP_STX = 2'b10,
      OP_JMP = 2'b11
   } mv_op_e;

   function automatic logic is_mem_op(mv_op_e op);
      return (op == OP_LDX) || (op == OP_STX);
   endfunction
endpackage

// File: rtl/mvc_decode.sv
`timescale 1ns/1ps
module mvc_decode #(
   parameter int RIDX_W  = 3,
   parameter int IMM_W   = 16,
   localparam int INSTR_W = mvc_pkg::OP_W + 3*RIDX_W + IMM_W
) (
   input  logic [INSTR_W-1:0] instr,
   output mvc_pkg::mv_op_e    op,
   output logic [RIDX_W-1:0]  r_idx,
   output logic [RIDX_W-1:0]  b_idx,
   output logic [RIDX_W-1:0]  o_idx,
   output logic [IMM_W-1:0]   imm
);
   localparam int R_LSB = IMM_W + 2*RIDX_W;
   localparam int B_LSB = IMM_W + RIDX_W;
   localparam int O_LSB = IMM_W;

   assign op    = mvc_pkg::mv_op_e'(instr[INSTR_W-1 -: mvc_pkg::OP_W]);
   assign r_idx = instr[R_LSB +: RIDX_W];
   assign b_idx = instr[B_LSB +: RIDX_W];
   assign o_idx = instr[O_LSB +: RIDX_W];
   assign imm   = instr[IMM_W-1:0];
endmodule

// File: rtl/mvc_agen.sv
`timescale 1ns/1ps
module mvc_agen #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] off_val,
   output logic [DATA_W-1:0] eff_addr,
   output logic              bad_operand,
   output logic              hits_zero
);
   // Cell address joined with a one-bit word select; no carry chain.
   assign eff_addr    = base_val | {{(DATA_W-1){1'b0}}, off_val[0]};
   assign bad_operand = base_val[0] | (|off_val[DATA_W-1:1]);
   assign hits_zero   = (eff_addr == '0);
endmodule

// File: rtl/mvc_regfile.sv
`timescale 1ns/1ps
module mvc_regfile #(
   parameter int DATA_W = 16,
   parameter int NREGS  = 8,
   localparam int RIDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [RIDX_W-1:0] ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              im_en,
   input  logic [RIDX_W-1:0] im_idx,
   input  logic [DATA_W-1:0] im_data,
   input  logic [RIDX_W-1:0] rd0_idx,
   input  logic [RIDX_W-1:0] rd1_idx,
   input  logic [RIDX_W-1:0] rd2_idx,
   output logic [DATA_W-1:0] rd0_q,
   output logic [DATA_W-1:0] rd1_q,
   output logic [DATA_W-1:0] rd2_q
);
   logic [DATA_W-1:0] regs [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      // The immediate port belongs to the younger instruction, so it wins.
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (im_en && (im_idx == RIDX_W'(g)))
            regs[g] <= im_data;
         else if (ld_en && (ld_idx == RIDX_W'(g)))
            regs[g] <= ld_data;
      end
   end

   assign rd0_q = regs[rd0_idx];
   assign rd1_q = regs[rd1_idx];
   assign rd2_q = regs[rd2_idx];

   AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (im_en && ld_en && im_idx == ld_idx) |=> (regs[$past(im_idx)] == $past(im_data))) // R6
      else $error("load overrode a younger immediate");
endmodule

// File: rtl/mvc_core.sv
`timescale 1ns/1ps
module mvc_core #(
   parameter int DATA_W = 16,
   parameter int IMM_W  = 16,
   parameter int NREGS  = 8,
   parameter int PC_W   = 8,
   parameter bit BYPASS = 1'b1,
   localparam int RIDX_W  = $clog2(NREGS),
   localparam int INSTR_W = mvc_pkg::OP_W + 3*RIDX_W + IMM_W
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PC_W-1:0]    imem_addr,
   input  logic [INSTR_W-1:0] imem_data,
   output logic [DATA_W-1:0]  dmem_addr,
   output logic               dmem_re,
   output logic               dmem_we,
   output logic [DATA_W-1:0]  dmem_wdata,
   input  logic [DATA_W-1:0]  dmem_rdata,
   output logic               halted,
   output logic               err_flag
);
   import mvc_pkg::*;

   initial begin
      if (DATA_W < 2)              $fatal(1, "DATA_W must be at least 2");
      if (IMM_W > DATA_W)          $fatal(1, "IMM_W may not exceed DATA_W");
      if (NREGS < 2 || (1 << RIDX_W) != NREGS)
                                   $fatal(1, "NREGS must be a power of two");
      if (PC_W < 1)                $fatal(1, "PC_W must be positive");
   end

   localparam int NPORT = 3;

   // ---------------- decode ----------------
   mv_op_e            op;
   logic [RIDX_W-1:0] r_idx, b_idx, o_idx;
   logic [IMM_W-1:0]  imm;

   mvc_decode #(.RIDX_W(RIDX_W), .IMM_W(IMM_W)) u_dec (
      .instr (imem_data),
      .op    (op),
      .r_idx (r_idx),
      .b_idx (b_idx),
      .o_idx (o_idx),
      .imm   (imm)
   );

   // ---------------- state ----------------
   logic [PC_W-1:0]   pc_q;
   logic              halt_q, err_q;
   logic              pend_q;
   logic [RIDX_W-1:0] pend_idx_q;

   logic exec;
   assign exec = !halt_q;

   // ---------------- register file with optional forwarding ----------------
   logic [RIDX_W-1:0] sel   [NPORT];
   logic [DATA_W-1:0] rf_q  [NPORT];
   logic [DATA_W-1:0] opnd  [NPORT];

   assign sel[0] = r_idx;
   assign sel[1] = b_idx;
   assign sel[2] = o_idx;

   logic im_wr;
   assign im_wr = exec && (op == OP_LDI);

   mvc_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (pend_q),
      .ld_idx  (pend_idx_q),
      .ld_data (dmem_rdata),
      .im_en   (im_wr),
      .im_idx  (r_idx),
      .im_data (DATA_W'(imm)),
      .rd0_idx (sel[0]),
      .rd1_idx (sel[1]),
      .rd2_idx (sel[2]),
      .rd0_q   (rf_q[0]),
      .rd1_q   (rf_q[1]),
      .rd2_q   (rf_q[2])
   );

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      if (BYPASS) begin : g_fwd
         assign opnd[p] = (pend_q && (pend_idx_q == sel[p])) ? dmem_rdata : rf_q[p];
      end else begin : g_nofwd
         assign opnd[p] = rf_q[p];
      end
   end

   // ---------------- address generation ----------------
   logic [DATA_W-1:0] eff;
   logic              bad_opnd, zero_hit;

   mvc_agen #(.DATA_W(DATA_W)) u_agen (
      .base_val    (opnd[1]),
      .off_val     (opnd[2]),
      .eff_addr    (eff),
      .bad_operand (bad_opnd),
      .hits_zero   (zero_hit)
   );

   logic mem_op, fault;
   assign mem_op = exec && is_mem_op(op);
   assign fault  = mem_op && zero_hit;

   // ---------------- data port ----------------
   assign dmem_addr  = eff;
   assign dmem_wdata = opnd[0];
   assign dmem_re    = exec && (op == OP_LDX) && !zero_hit;
   assign dmem_we    = exec && (op == OP_STX) && !zero_hit;

   // ---------------- sequencing ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q       <= '0;
         halt_q     <= 1'b0;
         err_q      <= 1'b0;
         pend_q     <= 1'b0;
         pend_idx_q <= '0;
      end else begin
         pend_q     <= dmem_re;
         pend_idx_q <= r_idx;
         if (fault)
            halt_q <= 1'b1;
         if (mem_op && bad_opnd)
            err_q <= 1'b1;
         if (exec && !fault)
            pc_q <= (op == OP_JMP) ? '0 : pc_q + PC_W'(1);
      end
   end

   assign imem_addr = pc_q;
   assign halted    = halt_q;
   assign err_flag  = err_q;

   // ---------------- checks ----------------
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted) // R8
      else $error("halted dropped without reset");

   AST_NO_ZERO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (dmem_re || dmem_we) |-> (dmem_addr != '0)) // R8
      else $error("strobe carried address zero");

   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!dmem_re && !dmem_we)) // R9
      else $error("strobe while halted");

   AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(imem_addr)) // R9
      else $error("fetch moved while halted");

   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && imem_data[INSTR_W-1 -: OP_W] == OP_JMP) |=> (imem_addr == '0)) // R7
      else $error("jump did not return to zero");

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag) // R10
      else $error("error flag cleared itself");

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dmem_re && dmem_we)) // R4
      else $error("read and write in one cycle");
endmodule

// File: tb/mvc_core_bench.sv
`timescale 1ns/1ps
module mvc_core_bench;
   localparam int DATA_W = 16;
   localparam int IMM_W  = 16;
   localparam int PC_W   = 8;
   localparam int INSTR_W = 27;
   localparam int ROM_N  = 64;
   localparam int MEM_N  = 256;

   localparam logic [1:0] LDI = 2'b00, LDX = 2'b01, STX = 2'b10, JMP = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [PC_W-1:0]    imem_addr;
   logic [INSTR_W-1:0] imem_data;
   logic [DATA_W-1:0]  dmem_addr, dmem_wdata;
   logic [DATA_W-1:0]  dmem_rdata = '0;
   logic               dmem_re, dmem_we, halted, err_flag;

   logic [INSTR_W-1:0] rom [ROM_N];
   logic [DATA_W-1:0]  mem [MEM_N];

   assign imem_data = rom[imem_addr[5:0]];

   mvc_core u_mvc_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_data  (imem_data),
      .dmem_addr  (dmem_addr),
      .dmem_re    (dmem_re),
      .dmem_we    (dmem_we),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata),
      .halted     (halted),
      .err_flag   (err_flag)
   );

   // data memory model with a preload path used only during reset
   logic              pre_we = 1'b0;
   logic              pre_clr = 1'b0;
   logic [7:0]        pre_addr = '0;
   logic [DATA_W-1:0] pre_data = '0;

   always @(posedge clk) begin
      if (pre_clr) begin
         for (int i = 0; i < MEM_N; i++) mem[i] <= '0;
      end else if (pre_we) begin
         mem[pre_addr] <= pre_data;
      end else begin
         if (dmem_we) mem[dmem_addr[7:0]] <= dmem_wdata;
         if (dmem_re) dmem_rdata <= mem[dmem_addr[7:0]];
      end
   end

   int checks = 0;
   int errors = 0;
   int quiet_bad = 0;

   always @(negedge clk)
      if (rst_n && halted && (dmem_re || dmem_we)) quiet_bad++;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [INSTR_W-1:0] enc(input logic [1:0] op, input int r,
                                             input int b, input int o,
                                             input logic [15:0] imm);
      return {op, 3'(r), 3'(b), 3'(o), imm};
   endfunction

   task automatic rom_fill_jump();
      for (int i = 0; i < ROM_N; i++) rom[i] = enc(JMP, 0, 0, 0, 16'h0);
   endtask

   task automatic preload(input logic [7:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      pre_we = 1'b1; pre_addr = a; pre_data = d;
      @(negedge clk);
      pre_we = 1'b0;
   endtask

   task automatic enter_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pre_clr = 1'b1;
      @(negedge clk);
      pre_clr = 1'b0;
   endtask

   task automatic leave_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // table of {base, offset, value}
   localparam int NV = 6;
   localparam logic [47:0] VEC [NV] = '{
      {16'h0010, 16'h0000, 16'hA5A5},
      {16'h0010, 16'h0001, 16'h5A5A},
      {16'h0022, 16'h0001, 16'h1234},
      {16'h0040, 16'h0000, 16'hFFFF},
      {16'h00FE, 16'h0001, 16'h0001},
      {16'h0002, 16'h0000, 16'h0BEE}
   };

   initial begin : watchdog
      #100us;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int pc;
      int jump_seen;

      // ---------- main program built from the table ----------
      rom_fill_jump();
      pc = 0;
      for (int v = 0; v < NV; v++) begin
         rom[pc++] = enc(LDI, 1, 0, 0, VEC[v][47:32]);
         rom[pc++] = enc(LDI, 2, 0, 0, VEC[v][31:16]);
         rom[pc++] = enc(LDI, 3, 0, 0, VEC[v][15:0]);
         rom[pc++] = enc(STX, 3, 1, 2, 16'h0);
         rom[pc++] = enc(LDI, 5, 0, 0, 16'(16'h0080 + 2*v));
         rom[pc++] = enc(LDI, 6, 0, 0, 16'h0000);
         rom[pc++] = enc(LDX, 4, 1, 2, 16'h0);
         rom[pc++] = enc(STX, 4, 5, 6, 16'h0);
      end
      rom[pc++] = enc(LDI, 5, 0, 0, 16'h0090);
      rom[pc++] = enc(LDX, 4, 1, 2, 16'h0);
      rom[pc++] = enc(LDI, 4, 0, 0, 16'h7777);
      rom[pc++] = enc(STX, 4, 5, 6, 16'h0);
      rom[pc]   = enc(JMP, 0, 0, 0, 16'h0);

      enter_reset();
      @(negedge clk);
      chk("R1", "imem_addr in reset", 32'(imem_addr), 32'h0);
      chk("R1", "strobes in reset", {30'h0, dmem_re, dmem_we}, 32'h0);
      chk("R1", "halted in reset", 32'(halted), 32'h0);
      chk("R1", "err_flag in reset", 32'(err_flag), 32'h0);
      leave_reset();
      chk("R1", "first fetch after reset", 32'(imem_addr), 32'h0);
      run(3);
      chk("R11", "fetch after three instructions", 32'(imem_addr), 32'h3);

      jump_seen = 0;
      for (int c = 0; c < 200 && jump_seen == 0; c++) begin
         if (imem_addr == 8'(pc)) begin
            run(1);
            chk("R7", "fetch after jump", 32'(imem_addr), 32'h0);
            jump_seen = 1;
         end else begin
            run(1);
         end
      end
      chk("R7", "jump reached", 32'(jump_seen), 32'h1);
      run(20);

      for (int v = 0; v < NV; v++) begin
         chk("R3", "stored word at base|offset",
             32'(mem[8'(VEC[v][47:32] | VEC[v][31:16])]), 32'(VEC[v][15:0]));
         chk("R5", "loaded word forwarded to next store",
             32'(mem[8'(8'h80 + 2*v)]), 32'(VEC[v][15:0]));
      end
      chk("R4", "even word of cell 0x10 unaffected by odd store", 32'(mem[8'h10]), 32'hA5A5);
      chk("R6", "immediate after load wins", 32'(mem[8'h90]), 32'h7777);
      chk("R10", "clean program leaves err low", 32'(err_flag), 32'h0);
      chk("R8", "clean program not halted", 32'(halted), 32'h0);

      // ---------- store to address zero ----------
      rom_fill_jump();
      rom[0] = enc(LDI, 1, 0, 0, 16'h0020);
      rom[1] = enc(LDI, 2, 0, 0, 16'h0000);
      rom[2] = enc(LDI, 3, 0, 0, 16'h0055);
      rom[3] = enc(LDI, 0, 0, 0, 16'h0000);
      rom[4] = enc(STX, 3, 0, 2, 16'h0);
      rom[5] = enc(STX, 3, 1, 2, 16'h0);
      enter_reset();
      preload(8'h20, 16'hDEAD);
      preload(8'h00, 16'h0BAD);
      leave_reset();
      quiet_bad = 0;
      run(20);
      chk("R8", "halted after store to zero", 32'(halted), 32'h1);
      chk("R8", "address zero not written", 32'(mem[0]), 32'h0BAD);
      chk("R9", "later store suppressed", 32'(mem[8'h20]), 32'hDEAD);
      chk("R9", "fetch frozen on faulting instruction", 32'(imem_addr), 32'h4);
      chk("R9", "strobe cycles while halted", 32'(quiet_bad), 32'h0);
      run(10);
      chk("R8", "halted still set", 32'(halted), 32'h1);
      chk("R10", "fault alone leaves err low", 32'(err_flag), 32'h0);

      // ---------- load from address zero ----------
      rom_fill_jump();
      rom[0] = enc(LDX, 4, 0, 0, 16'h0);
      rom[1] = enc(LDI, 1, 0, 0, 16'h0030);
      rom[2] = enc(STX, 1, 1, 0, 16'h0);
      enter_reset();
      chk("R1", "reset clears halted", 32'(halted), 32'h0);
      leave_reset();
      run(8);
      chk("R8", "halted after load from zero", 32'(halted), 32'h1);
      chk("R9", "fetch frozen at zero", 32'(imem_addr), 32'h0);
      chk("R9", "no store after load fault", 32'(mem[8'h30]), 32'h0);

      // ---------- odd base ----------
      rom_fill_jump();
      rom[0] = enc(LDI, 1, 0, 0, 16'h0021);
      rom[1] = enc(LDI, 2, 0, 0, 16'h0000);
      rom[2] = enc(LDX, 4, 1, 2, 16'h0);
      enter_reset();
      leave_reset();
      run(2);
      chk("R10", "err low before bad access", 32'(err_flag), 32'h0);
      run(10);
      chk("R10", "odd base sets err", 32'(err_flag), 32'h1);
      chk("R10", "odd base does not halt", 32'(halted), 32'h0);

      // ---------- offset above one ----------
      rom_fill_jump();
      rom[0] = enc(LDI, 1, 0, 0, 16'h0040);
      rom[1] = enc(LDI, 2, 0, 0, 16'h0002);
      rom[2] = enc(LDI, 3, 0, 0, 16'h0000);
      rom[3] = enc(STX, 1, 1, 3, 16'h0);
      rom[4] = enc(STX, 1, 1, 2, 16'h0);
      enter_reset();
      chk("R1", "reset clears err", 32'(err_flag), 32'h0);
      leave_reset();
      run(4);
      chk("R10", "legal store keeps err low", 32'(err_flag), 32'h0);
      chk("R4", "legal store value", 32'(mem[8'h40]), 32'h0040);
      run(10);
      chk("R10", "offset of two sets err", 32'(err_flag), 32'h1);
      chk("R2", "imm zero-extended into register", 32'(mem[8'h40]), 32'h0040);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule